// File: doc/BRIEF.md
# Egress Queue Scheduler with Strict-Priority and Weighted Round-Robin Tiers

This block picks which of eight egress queues of one port sends its next frame. Queue 7 has the highest priority and queue 0 the lowest. A programmable group size N places the N lowest-numbered queues into a deficit-based weighted round-robin tier. Every queue at or above index N is served in strict priority order. A waiting strict queue always wins over the whole weighted tier.

Each queue reports whether it holds a frame and the length of the frame at its head. The block answers with a registered one-hot grant. The grant stays in place until the downstream side signals `accept` for one cycle. Inside the weighted tier, each queue has a 5-bit cost. The cost is an inverse weight: serving a frame charges length x (cost + 1) against that queue's deficit counter. A higher cost therefore means a smaller share of the bandwidth.

Configuration writes go into a staging copy. That copy moves into the live configuration only at a frame boundary. A round-robin mode bit swaps the weighted tier for plain frame-by-frame rotation.

Top module: `hsched_top`

## Requirements
- R1: After reset the grant is all zeros and the live configuration is group size 0, round-robin mode off and every cost 0, so all eight queues are scheduled in strict priority.
- R2: Among non-empty queues whose index is N or above, the grant goes to the highest index.
- R3: While any queue with index N or above is non-empty, no queue with index below N is granted.
- R4: The grant is one-hot or zero. Once issued it holds unchanged until `accept` is sampled high, and in the cycle after that it is zero. A new grant is decided only in a cycle where the grant is zero.
- R5: Each weighted-tier queue keeps a signed deficit. An accepted grant charges head length x (cost + 1) to it. Only non-empty tier queues with a positive deficit are candidates. Candidates are searched in rising index order with wrap-around, starting one index after the last weighted-tier grant.
- R6: In a decision cycle where no strict queue is non-empty, and some tier queue is non-empty but none of them is a candidate, every non-empty tier queue gains QUANTUM and no grant is issued that cycle.
- R7: The deficit of a queue that is empty, or that is outside the tier, is cleared to zero.
- R8: With round-robin mode on, every non-empty tier queue is a candidate regardless of deficit or cost. The tier then rotates one frame per queue.
- R9: Register map. Address 0 takes the group size N in bits [3:0] and the round-robin mode in bit 4. Addresses 8 to 15 take the cost of queue (address - 8) in bits [4:0].
- R10: Writes reach the live configuration only at the end of a cycle where the grant is zero or `accept` is high. The charge for an accepted frame uses the configuration that was live while it was granted.
- R11: When no queue is non-empty, the grant stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_nonempty | input | 8 | Per-queue frame-present flags |
| q_len | input | 8*LEN_W | Head frame length per queue, queue q at bits [q*LEN_W +: LEN_W] |
| accept | input | 1 | Downstream takes the granted frame this cycle |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_data | input | 5 | Register write data |
| grant | output | 8 | One-hot queue grant, zero when idle |

## Verification
A corrupted deficit counter does not stop grants. It shows up as a wrong share of grants between weighted-tier queues within one replenish round, which is a few dozen frames. A stale deficit carried over an empty spell shows on the very next grant, because a queue that should have been rotated past is picked instead. A wrong rotation pointer shows at the next tier decision. If the staging copy applies its values early, the extra charge delays the following grant by several replenish cycles, and that delay is visible on the first frame after the boundary.

// File: rtl/hsched_pkg.sv
package hsched_pkg;
    localparam int NQ        = 8;
    localparam int QIDX_W    = $clog2(NQ);
    localparam int CNT_W     = $clog2(NQ + 1);
    localparam int COST_W    = 5;
    localparam int CTRL_W    = CNT_W + 1;
    localparam int DATA_W    = (CTRL_W > COST_W) ? CTRL_W : COST_W;
    localparam int ADDR_W    = 4;
    localparam int CTRL_ADDR = 0;
    localparam int COST_BASE = 8;

    typedef struct packed {
        logic [CNT_W-1:0] grp_n;
        logic             rr_en;
    } ctrl_t;

    typedef logic [NQ-1:0][COST_W-1:0] cost_arr_t;

    function automatic logic [NQ-1:0] grp_mask(input logic [CNT_W-1:0] n);
        logic [NQ-1:0] m;
        for (int q = 0; q < NQ; q++) begin
            m[q] = (q < int'(n));
        end
        return m;
    endfunction
endpackage

// File: rtl/hsched_cfg.sv
module hsched_cfg
    import hsched_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              apply,
    output ctrl_t             act_ctrl,
    output cost_arr_t         act_cost
);
    ctrl_t     stg_ctrl;
    cost_arr_t stg_cost;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_ctrl <= '0;
            stg_cost <= '0;
        end else if (wr_en) begin
            if (int'(wr_addr) == CTRL_ADDR) begin
                stg_ctrl.grp_n <= wr_data[CNT_W-1:0];
                stg_ctrl.rr_en <= wr_data[CNT_W];
            end else if (int'(wr_addr) >= COST_BASE &&
                         int'(wr_addr) < COST_BASE + NQ) begin
                stg_cost[wr_addr[QIDX_W-1:0]] <= wr_data[COST_W-1:0];
            end
        end
    end

    // live copy only moves at a frame boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            act_ctrl <= '0;
            act_cost <= '0;
        end else if (apply) begin
            act_ctrl <= stg_ctrl;
            act_cost <= stg_cost;
        end
    end
endmodule

// File: rtl/hsched_sp.sv
module hsched_sp
    import hsched_pkg::*;
(
    input  logic [NQ-1:0] elig,
    output logic          hit,
    output logic [NQ-1:0] pick_oh
);
    always_comb begin
        pick_oh = '0;
        for (int q = 0; q < NQ; q++) begin
            if (elig[q]) begin
                pick_oh    = '0;
                pick_oh[q] = 1'b1;
            end
        end
        hit = |elig;
    end
endmodule

// File: rtl/hsched_dwrr.sv
module hsched_dwrr
    import hsched_pkg::*;
#(
    parameter int LEN_W   = 12,
    parameter int QUANTUM = 2048
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NQ-1:0]               nonempty,
    input  logic [NQ-1:0][LEN_W-1:0]    len,
    input  logic [NQ-1:0]               grp,
    input  cost_arr_t                   cost,
    input  logic                        rr_en,
    input  logic                        decide,
    input  logic [NQ-1:0]               charge_oh,
    output logic                        pick_ok,
    output logic [NQ-1:0]               pick_oh
);
    localparam int PROD_W = LEN_W + COST_W + 1;
    localparam int DEF_W  = PROD_W + 1;

    logic signed [DEF_W-1:0]  def_q [NQ];
    logic [PROD_W-1:0]        chg   [NQ];
    logic [NQ-1:0]            live;
    logic [NQ-1:0]            cand;
    logic                     refill;
    logic [QIDX_W-1:0]        ptr_q;
    logic [QIDX_W-1:0]        ptr_nxt;
    logic [QIDX_W-1:0]        idx;

    always_comb begin
        for (int q = 0; q < NQ; q++) begin
            chg[q]  = PROD_W'(len[q]) * PROD_W'(cost[q]) + PROD_W'(len[q]);
            live[q] = nonempty[q] & grp[q];
            cand[q] = live[q] & (rr_en | (!def_q[q][DEF_W-1] && def_q[q] != '0));
        end
        refill = !rr_en && (|live) && !(|cand);
    end

    always_comb begin
        pick_oh = '0;
        pick_ok = 1'b0;
        ptr_nxt = ptr_q;
        idx     = ptr_q;
        for (int k = 0; k < NQ; k++) begin
            idx = ptr_q + QIDX_W'(k);
            if (!pick_ok && cand[idx]) begin
                pick_ok      = 1'b1;
                pick_oh[idx] = 1'b1;
                ptr_nxt      = idx + QIDX_W'(1);
            end
        end
    end

    generate
        for (genvar q = 0; q < NQ; q++) begin : g_def
            always_ff @(posedge clk) begin
                if (rst) begin
                    def_q[q] <= '0;
                end else if (!live[q] || rr_en) begin
                    def_q[q] <= '0;
                end else if (charge_oh[q]) begin
                    def_q[q] <= def_q[q] - DEF_W'(chg[q]);
                end else if (decide && refill) begin
                    def_q[q] <= def_q[q] + DEF_W'(QUANTUM);
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (decide && pick_ok) begin
            ptr_q <= ptr_nxt;
        end
    end
endmodule

// File: rtl/hsched_top.sv
module hsched_top
    import hsched_pkg::*;
#(
    parameter int LEN_W   = 12,
    parameter int QUANTUM = 2048
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NQ-1:0]         q_nonempty,
    input  logic [NQ*LEN_W-1:0]   q_len,
    input  logic                  accept,
    input  logic                  cfg_wr,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [DATA_W-1:0]     cfg_data,
    output logic [NQ-1:0]         grant
);
    logic [NQ-1:0]            grant_q;
    logic [NQ-1:0]            grant_d;
    logic [NQ-1:0][LEN_W-1:0] len_arr;
    ctrl_t                    act_ctrl;
    cost_arr_t                act_cost;
    logic [NQ-1:0]            grp;
    logic                     idle;
    logic                     sp_hit;
    logic [NQ-1:0]            sp_oh;
    logic                     dw_ok;
    logic [NQ-1:0]            dw_oh;

    generate
        for (genvar q = 0; q < NQ; q++) begin : g_len
            assign len_arr[q] = q_len[q*LEN_W +: LEN_W];
        end
    endgenerate

    assign idle = (grant_q == '0);
    assign grp  = grp_mask(act_ctrl.grp_n);

    hsched_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_data),
        .apply    (idle || accept),
        .act_ctrl (act_ctrl),
        .act_cost (act_cost)
    );

    hsched_sp u_sp (
        .elig    (q_nonempty & ~grp),
        .hit     (sp_hit),
        .pick_oh (sp_oh)
    );

    hsched_dwrr #(
        .LEN_W   (LEN_W),
        .QUANTUM (QUANTUM)
    ) u_dwrr (
        .clk       (clk),
        .rst       (rst),
        .nonempty  (q_nonempty),
        .len       (len_arr),
        .grp       (grp),
        .cost      (act_cost),
        .rr_en     (act_ctrl.rr_en),
        .decide    (idle && !sp_hit),
        .charge_oh (accept ? grant_q : '0),
        .pick_ok   (dw_ok),
        .pick_oh   (dw_oh)
    );

    always_comb begin
        grant_d = grant_q;
        if (idle) begin
            if (sp_hit)     grant_d = sp_oh;
            else if (dw_ok) grant_d = dw_oh;
            else            grant_d = '0;
        end else if (accept) begin
            grant_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) grant_q <= '0;
        else     grant_q <= grant_d;
    end

    assign grant = grant_q;
endmodule

// File: rtl/hsched_chk.sv
module hsched_chk
    import hsched_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [NQ-1:0] grant,
    input logic          accept,
    input logic [NQ-1:0] q_nonempty
);
    a_r4_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && !accept) |=> $stable(grant));

    a_r4_release: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && accept) |=> grant == '0);

    a_r11_idle: assert property (@(posedge clk) disable iff (rst)
        (grant == '0 && q_nonempty == '0) |=> grant == '0);

    a_r4_live_queue: assert property (@(posedge clk) disable iff (rst)
        (grant == '0) |=> (grant == '0) || ((grant & $past(q_nonempty)) != '0));
endmodule

bind hsched_top hsched_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .grant      (grant),
    .accept     (accept),
    .q_nonempty (q_nonempty)
);

// File: tb/hsched_top_tb_top.sv
`timescale 1ns/1ps
module hsched_top_tb_top;
    import hsched_pkg::*;

    localparam int LEN_W   = 12;
    localparam int QUANTUM = 2048;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NQ-1:0]       q_nonempty = '0;
    logic [NQ*LEN_W-1:0] q_len = '0;
    logic                accept = 1'b0;
    logic                cfg_wr = 1'b0;
    logic [ADDR_W-1:0]   cfg_addr = '0;
    logic [DATA_W-1:0]   cfg_data = '0;
    logic [NQ-1:0]       grant;

    int n_checks = 0;
    int n_err    = 0;

    always #2.5 clk = ~clk;

    hsched_top #(.LEN_W(LEN_W), .QUANTUM(QUANTUM)) dut_i (
        .clk(clk), .rst(rst), .q_nonempty(q_nonempty), .q_len(q_len),
        .accept(accept), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .grant(grant)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        cfg_wr   = 1'b1;
        cfg_addr = ADDR_W'(addr);
        cfg_data = DATA_W'(data);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_grant(output logic [NQ-1:0] g);
        g = '0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (grant != '0) begin
                g = grant;
                break;
            end
        end
    endtask

    task automatic take();
        accept = 1'b1;
        @(negedge clk);
        accept = 1'b0;
    endtask

    task automatic drain();
        q_nonempty = '0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (grant != '0) take();
        end
    endtask

    task automatic count_grants(input int n, output int c0, output int c1, output int c2);
        logic [NQ-1:0] g;
        c0 = 0; c1 = 0; c2 = 0;
        for (int i = 0; i < n; i++) begin
            wait_grant(g);
            if (g == 8'h01) c0++;
            if (g == 8'h02) c1++;
            if (g == 8'h04) c2++;
            take();
        end
    endtask

    task automatic t_reset_strict();
        logic [NQ-1:0] g;
        @(negedge clk);
        chk("R1 reset grant", grant, 0);
        q_nonempty = 8'b1011_0010;
        wait_grant(g);
        chk("R1 R2 highest strict", g, 8'h80);
        repeat (3) @(negedge clk);
        chk("R4 held without accept", grant, 8'h80);
        take();
        chk("R4 zero after accept", grant, 0);
        q_nonempty[7] = 1'b0;
        wait_grant(g);
        chk("R2 next strict", g, 8'h20);
        take();
        q_nonempty[5] = 1'b0;
        wait_grant(g);
        chk("R2 third strict", g, 8'h10);
        take();
        q_nonempty[4] = 1'b0;
        wait_grant(g);
        chk("R2 lowest strict", g, 8'h02);
        take();
        drain();
    endtask

    task automatic t_strict_over_group();
        logic [NQ-1:0] g;
        wr(CTRL_ADDR, 4);
        settle();
        q_nonempty = 8'h23;
        wait_grant(g);
        chk("R3 strict beats group", g, 8'h20);
        take();
        q_nonempty[5] = 1'b0;
        wait_grant(g);
        chk("R3 group after strict", int'((g & 8'h03) != 0 && $onehot(g)), 1);
        take();
        drain();
    endtask

    task automatic t_idle();
        int bad = 0;
        wr(CTRL_ADDR, 0);
        q_nonempty = '0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (grant != '0) bad++;
        end
        chk("R11 idle grant zero", bad, 0);
    endtask

    task automatic t_refill();
        wr(CTRL_ADDR, 1);
        wr(COST_BASE + 0, 0);
        settle();
        q_nonempty = 8'h01;
        @(negedge clk);
        chk("R6 refill cycle has no grant", grant, 0);
        @(negedge clk);
        chk("R6 grant after refill", grant, 8'h01);
        take();
        drain();
    endtask

    task automatic t_ratio();
        int c0, c1, c2;
        wr(CTRL_ADDR, 2);
        wr(COST_BASE + 0, 0);
        wr(COST_BASE + 1, 1);
        settle();
        q_nonempty = 8'h03;
        count_grants(60, c0, c1, c2);
        chk("R5 R9 cost0 share", c0, 40);
        chk("R5 R9 cost1 share", c1, 20);
        drain();
    endtask

    task automatic t_equal();
        int c0, c1, c2;
        wr(CTRL_ADDR, 3);
        wr(COST_BASE + 0, 0);
        wr(COST_BASE + 1, 0);
        wr(COST_BASE + 2, 0);
        settle();
        q_nonempty = 8'h07;
        count_grants(60, c0, c1, c2);
        chk("R5 equal q0", c0, 20);
        chk("R5 equal q1", c1, 20);
        chk("R5 equal q2", c2, 20);
        drain();
    endtask

    task automatic t_rr();
        int c0, c1, c2;
        wr(CTRL_ADDR, 2 | (1 << CNT_W));
        wr(COST_BASE + 0, 0);
        wr(COST_BASE + 1, 31);
        settle();
        q_nonempty = 8'h03;
        count_grants(60, c0, c1, c2);
        chk("R8 rr q0", c0, 30);
        chk("R8 rr q1", c1, 30);
        drain();
    endtask

    task automatic t_empty_clear();
        logic [NQ-1:0] g;
        wr(CTRL_ADDR, 2);
        wr(COST_BASE + 0, 0);
        wr(COST_BASE + 1, 0);
        settle();
        q_nonempty = 8'h01;
        wait_grant(g);
        chk("R7 lone q0 grant", g, 8'h01);
        take();
        q_nonempty = '0;
        repeat (3) @(negedge clk);
        q_nonempty = 8'h03;
        wait_grant(g);
        chk("R7 credit dropped while empty", g, 8'h02);
        take();
        drain();
    endtask

    task automatic t_boundary();
        logic [NQ-1:0] g;
        wr(CTRL_ADDR, 1);
        wr(COST_BASE + 0, 0);
        settle();
        q_nonempty = 8'h01;
        wait_grant(g);
        chk("R10 first grant", g, 8'h01);
        wr(COST_BASE + 0, 31);
        repeat (2) @(negedge clk);
        chk("R10 R4 grant held over write", grant, 8'h01);
        take();
        @(negedge clk);
        chk("R10 old cost charged", grant, 8'h01);
        take();
        drain();
    endtask

    initial begin
        for (int q = 0; q < NQ; q++) q_len[q*LEN_W +: LEN_W] = LEN_W'(256);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset_strict();
        t_strict_over_group();
        t_idle();
        t_refill();
        t_ratio();
        t_equal();
        t_rr();
        t_empty_clear();
        t_boundary();
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule